// File: doc/BRIEF.md
# Fractional Oversampling Baud Tick Generator

This block makes the timing strobe that a UART transmitter and receiver share. It runs from one reference clock. It emits a single-cycle pulse at sixteen times the programmed baud rate. The period is set by an integer divisor plus a 6-bit fraction in sixty-fourths of a reference cycle. A fractional accumulator stretches some periods by one cycle, so the long-run average rate matches the fractional setting. The counters run freely and need no restart for each frame.

A second strobe comes from its own 8-bit divisor. It paces the narrow pulses used for low-power infrared encoding of transmit bits. Both strobes stop while the enable input is low. Each strobe also stops when its divisor is too small to form a pulse train. When a divisor value changes, its counter reloads and the period starts again.

Rates up to 460.8 kbit/s are reached with an integer divisor of 2 and a reference clock of at least 14.7456 MHz.

Top module: `baud_tick_gen`

## Requirements
- R1: With `frac_div` = 0 and `int_div` = N (N >= 2), `tick16` rises once every N reference cycles, and keeps doing so for as long as the settings do not change.
- R2: `tick16` and `lp_tick` are each high for exactly one reference cycle at a time. Neither is ever high on two consecutive cycles.
- R3: At every `tick16`, `frac_div` is added to a 6-bit accumulator. The carry out of that addition makes the next period N+1 cycles instead of N. Over 64 periods after a restart, the total length is exactly 64*N + `frac_div` cycles.
- R4: When `int_div` is 0 or 1, `tick16` stays low.
- R5: A change of `int_div` or `frac_div` clears the counter and the accumulator. The first `tick16` then arrives on the (N+1)th rising edge, counting the edge that first samples the new value as the first.
- R6: While `enable` is low, both ticks stay low and the counters hold at their start. After `enable` goes high, the first `tick16` arrives on the Nth rising edge, counting the first edge that samples `enable` high as the first.
- R7: With `lp_div` = L (L >= 2), `lp_tick` rises once every L cycles, whatever the settings of the main divider.
- R8: When `lp_div` is 0 or 1, `lp_tick` stays low. A change of `lp_div` restarts the low-power count.
- R9: While `rst_n` is low, both ticks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run both dividers when high |
| int_div | input | 16 | Integer part of the x16 divisor |
| frac_div | input | 6 | Fractional part of the divisor, in 1/64 steps |
| lp_div | input | 8 | Divisor for the low-power infrared strobe |
| tick16 | output | 1 | Single-cycle strobe at sixteen times the baud rate |
| lp_tick | output | 1 | Single-cycle low-power infrared timing strobe |

## Verification
The main divider is tested with a zero fraction at the smallest divisor and at a mid-range divisor. A fault in the count limit shows there as a fixed period error. It is also tested with fractions 32, 63 and 1. These predict different patterns of long and short periods, so a wrong carry order, a swapped accumulator update or an off-by-one accumulator width fails on at least one of them. Runs at divisors 0 and 1, mid-run divisor changes and enable toggling separate the restart behaviour from the steady state. The low-power strobe runs beside an active main divider, which shows that the two counts are independent.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int IDIV_W  = 16,
  parameter int FDIV_W  = 6,
  parameter int LPDIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [IDIV_W-1:0]  int_div,
  input  logic [FDIV_W-1:0]  frac_div,
  input  logic [LPDIV_W-1:0] lp_div,
  output logic               tick16,
  output logic               lp_tick
);

  logic [IDIV_W-1:0]  cnt, idiv_q;
  logic [FDIV_W-1:0]  acc, fdiv_q;
  logic               ext;
  logic [LPDIV_W-1:0] lp_cnt, lp_q;

  wire main_on     = enable && (int_div > IDIV_W'(1));
  wire main_reload = (int_div != idiv_q) || (frac_div != fdiv_q);
  wire [IDIV_W-1:0] limit   = int_div - IDIV_W'(1) + IDIV_W'(ext);
  wire [FDIV_W:0]   acc_sum = {1'b0, acc} + {1'b0, frac_div};
  wire main_hit    = (cnt == limit);

  wire lp_on     = enable && (lp_div > LPDIV_W'(1));
  wire lp_reload = (lp_div != lp_q);
  wire [LPDIV_W-1:0] lp_limit = lp_div - LPDIV_W'(1);
  wire lp_hit    = (lp_cnt == lp_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      ext    <= 1'b0;
      idiv_q <= '0;
      fdiv_q <= '0;
      tick16 <= 1'b0;
    end else begin
      idiv_q <= int_div;
      fdiv_q <= frac_div;
      if (!main_on || main_reload) begin
        cnt    <= '0;
        acc    <= '0;
        ext    <= 1'b0;
        tick16 <= 1'b0;
      end else if (main_hit) begin
        cnt        <= '0;
        {ext, acc} <= acc_sum;
        tick16     <= 1'b1;
      end else begin
        cnt    <= cnt + IDIV_W'(1);
        tick16 <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_cnt  <= '0;
      lp_q    <= '0;
      lp_tick <= 1'b0;
    end else begin
      lp_q <= lp_div;
      if (!lp_on || lp_reload) begin
        lp_cnt  <= '0;
        lp_tick <= 1'b0;
      end else if (lp_hit) begin
        lp_cnt  <= '0;
        lp_tick <= 1'b1;
      end else begin
        lp_cnt  <= lp_cnt + LPDIV_W'(1);
        lp_tick <= 1'b0;
      end
    end
  end

  assert_single_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> !tick16);

  assert_single_lp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_tick |=> !lp_tick);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (main_on && !main_reload) |-> (cnt <= limit));

  assert_lp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_on && !lp_reload) |-> (lp_cnt <= lp_limit));

  assert_enabled_before_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |-> $past(enable));

  assert_lp_div_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_tick |-> ($past(lp_div) > LPDIV_W'(1)));

endmodule

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] int_div = '0;
  logic [5:0]  frac_div = '0;
  logic [7:0]  lp_div = '0;
  logic        tick16, lp_tick;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .int_div(int_div),
    .frac_div(frac_div), .lp_div(lp_div), .tick16(tick16), .lp_tick(lp_tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_main(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!tick16 && n < 5000);
  endtask

  task automatic next_lp(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!lp_tick && n < 5000);
  endtask

  task automatic count_ticks(input int len, output int nm, output int nl);
    nm = 0; nl = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick16) nm++;
      if (lp_tick) nl++;
    end
  endtask

  task automatic set_div(input int n, input int f);
    @(negedge clk);
    int_div = '0;
    @(negedge clk);
    int_div = 16'(n);
    frac_div = 6'(f);
  endtask

  task automatic t_reset();
    int nm, nl;
    @(negedge clk);
    check(!tick16 && !lp_tick, "R9 reset ticks low", int'(tick16) + int'(lp_tick), 0);
    int_div = 16'd4; lp_div = 8'd5;
    rst_n = 1'b1;
    count_ticks(60, nm, nl);
    check(nm + nl == 0, "R6 enable low blocks ticks", nm + nl, 0);
  endtask

  task automatic t_int_period(input int n);
    int d;
    enable = 1'b1;
    set_div(n, 0);
    next_main(d);
    for (int i = 0; i < 6; i++) begin
      next_main(d);
      check(d == n, "R1 integer period", d, n);
    end
    @(posedge clk); @(negedge clk);
    check(!tick16, "R2 main pulse single cycle", int'(tick16), 0);
  endtask

  task automatic t_frac(input int n, input int f);
    int d, tot, exp_d;
    int acc_m, ext_m;
    set_div(n, f);
    next_main(d);
    acc_m = f % 64; ext_m = 0;
    tot = 0;
    for (int i = 0; i < 64; i++) begin
      exp_d = n + ext_m;
      next_main(d);
      tot += d;
      check(d == exp_d, "R3 fractional period", d, exp_d);
      acc_m = acc_m + f;
      ext_m = acc_m / 64;
      acc_m = acc_m % 64;
    end
    check(tot == 64 * n + f, "R3 total of 64 periods", tot, 64 * n + f);
  endtask

  task automatic t_zero_div();
    int nm, nl;
    @(negedge clk); int_div = 16'd0; frac_div = 6'd9;
    count_ticks(300, nm, nl);
    check(nm == 0, "R4 divisor 0 holds tick low", nm, 0);
    @(negedge clk); int_div = 16'd1;
    count_ticks(300, nm, nl);
    check(nm == 0, "R4 divisor 1 holds tick low", nm, 0);
  endtask

  task automatic t_reload();
    int d;
    set_div(10, 0);
    next_main(d);
    repeat (4) @(negedge clk);
    int_div = 16'd7;
    next_main(d);
    check(d == 8, "R5 reload on divisor change", d, 8);
    next_main(d);
    check(d == 7, "R5 period after reload", d, 7);
    next_main(d);
    repeat (2) @(negedge clk);
    frac_div = 6'd20;
    next_main(d);
    check(d == 8, "R5 reload on fraction change", d, 8);
  endtask

  task automatic t_enable();
    int d, nm, nl;
    set_div(9, 0);
    lp_div = 8'd4;
    next_main(d);
    enable = 1'b0;
    count_ticks(40, nm, nl);
    check(nm == 0 && nl == 0, "R6 disable stops both ticks", nm + nl, 0);
    enable = 1'b1;
    next_main(d);
    check(d == 9, "R6 first tick after enable", d, 9);
  endtask

  task automatic t_lp(input int l);
    int d;
    set_div(13, 5);
    @(negedge clk); lp_div = 8'd0;
    @(negedge clk); lp_div = 8'(l);
    next_lp(d);
    for (int i = 0; i < 5; i++) begin
      next_lp(d);
      check(d == l, "R7 low-power period", d, l);
    end
    @(posedge clk); @(negedge clk);
    check(!lp_tick, "R2 low-power pulse single cycle", int'(lp_tick), 0);
  endtask

  task automatic t_lp_off();
    int d, nm, nl;
    @(negedge clk); lp_div = 8'd0;
    count_ticks(200, nm, nl);
    check(nl == 0, "R8 lp divisor 0 holds low", nl, 0);
    @(negedge clk); lp_div = 8'd1;
    count_ticks(200, nm, nl);
    check(nl == 0, "R8 lp divisor 1 holds low", nl, 0);
    @(negedge clk); lp_div = 8'd6;
    next_lp(d);
    next_lp(d);
    repeat (2) @(negedge clk);
    lp_div = 8'd3;
    next_lp(d);
    check(d == 4, "R8 lp restart on change", d, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_int_period(2);
    t_int_period(11);
    t_frac(3, 32);
    t_frac(2, 63);
    t_frac(5, 1);
    t_zero_div();
    t_reload();
    t_enable();
    t_lp(3);
    t_lp(37);
    t_lp_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule